// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Controller

This block collects interrupt requests from up to eight transmit channels, up to eight receive channels and one DMA host-error source. Each source appears as a bit of a raw status view. A per-group enable mask filters the raw bits into a masked view. Software never writes a mask directly. One register alias turns enable bits on and a second alias turns them off, so separate agents can change single bits without a read-modify-write race.

The masked bits of all three groups are OR-ed into one pending condition. That condition drives a single-cycle interrupt pulse. After each pulse the output is disarmed. Software re-arms it by writing the end-of-interrupt register. If masked sources are still pending at that point, the pulse fires again straight away.

Software reaches the block through a plain single-cycle register port. A write takes effect on the clock edge where `reg_wr` is sampled high. Read data appears on `reg_rdata` after the edge where `reg_rd` is sampled high. The port has no back-pressure: it accepts every access on every cycle, so it needs no valid/ready pair. Source inputs are level signals, sampled as they are.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset all three masks are zero, `irq_pulse` is low, `reg_rdata` is zero, and the output is armed.
- R2: A write to a mask-set alias (transmit 0x88, receive 0xA8, DMA 0xB8) sets the mask bits that are 1 in the write data. Bits written as 0 leave the mask unchanged.
- R3: A write to a mask-clear alias (transmit 0x8C, receive 0xAC, DMA 0xBC) clears the mask bits that are 1 in the write data. Writing all ones clears every bit of that group.
- R4: A read of either the set alias or the clear alias of a group returns that group's current mask, zero-extended.
- R5: The raw status registers (transmit 0x80, receive 0xA0, DMA 0xB0) return the source levels whatever the mask. The masked status registers (0x84, 0xA4, 0xB4) return raw AND mask.
- R6: Transmit or receive channel n drives bit n of its group. The host-error source drives bit 1 of the DMA group. DMA bit 0 and all higher DMA bits always read 0, even after a set write of all ones.
- R7: While armed, `irq_pulse` goes high for exactly one cycle, on the cycle after any masked bit becomes set, and the output is then disarmed. While disarmed, no further pulse occurs, even if new masked bits appear.
- R8: Any write to 0x94 (end-of-interrupt) re-arms the output. If masked bits are still pending, `irq_pulse` goes high on the cycle after the write edge. If none are pending, no pulse occurs until one appears.
- R9: A read of 0x90 returns the transmit masked status in bits 7:0 and the receive masked status in bits 15:8. All other bits read 0.
- R10: A write to a status register, to 0x90 or to an unmapped address changes no mask and no armed state. A read of 0x94 or of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_src | input | NUM_TX | Transmit channel request levels |
| rx_src | input | NUM_RX | Receive channel request levels |
| host_err | input | 1 | DMA host-error request level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| irq_pulse | output | 1 | Combined interrupt pulse |

## Verification
The bench builds the block with its defaults: eight transmit channels, eight receive channels, an 8-bit address and 32-bit data. With eight channels per group the input-vector layout fills its full 16 bits, so the highest channel bit is exercised. The 32-bit data width lets an all-ones write reach every unimplemented mask bit, including the DMA group's unused bit 0. A scoreboard queue holds the expected read results. Pulse timing is checked cycle by cycle around mask writes and end-of-interrupt writes, both while armed and while disarmed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [7:0] A_TX_RAW = 8'h80;
  localparam logic [7:0] A_TX_MSK = 8'h84;
  localparam logic [7:0] A_TX_SET = 8'h88;
  localparam logic [7:0] A_TX_CLR = 8'h8C;
  localparam logic [7:0] A_VECTOR = 8'h90;
  localparam logic [7:0] A_EOI    = 8'h94;
  localparam logic [7:0] A_RX_RAW = 8'hA0;
  localparam logic [7:0] A_RX_MSK = 8'hA4;
  localparam logic [7:0] A_RX_SET = 8'hA8;
  localparam logic [7:0] A_RX_CLR = 8'hAC;
  localparam logic [7:0] A_DM_RAW = 8'hB0;
  localparam logic [7:0] A_DM_MSK = 8'hB4;
  localparam logic [7:0] A_DM_SET = 8'hB8;
  localparam logic [7:0] A_DM_CLR = 8'hBC;
  localparam int DMA_W = 2;
  localparam logic [DMA_W-1:0] DMA_IMPL = 2'b10;
endpackage

// File: rtl/irq_mask_group.sv
module irq_mask_group #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] masked
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q[i] <= 1'b0;
        else if (set_we && wbits[i]) mask_q[i] <= 1'b1;
        else if (clr_we && wbits[i]) mask_q[i] <= 1'b0;
      end
    end else begin : g_tied
      assign mask_q[i] = 1'b0;
    end
  end

  assign masked = src & mask_q;

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(wbits)) == ($past(wbits) & IMPL)));
  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(wbits)) == '0));
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/irq_arm.sv
module irq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic eoi_wr,
  output logic irq_pulse
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b1;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= armed_q && pending;
      if (eoi_wr)                  armed_q <= 1'b1;
      else if (armed_q && pending) armed_q <= 1'b0;
    end
  end

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !$past(eoi_wr)) |=> !irq_pulse);
  // R8
  eoi_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && pending) |=> ##1 irq_pulse || !$past(pending));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int NUM_TX = 8,
  parameter int NUM_RX = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TX-1:0] tx_src,
  input  logic [NUM_RX-1:0] rx_src,
  input  logic              host_err,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pulse
);
  import irq_pkg::*;

  localparam int VEC_PAD = DATA_W - NUM_TX - NUM_RX;

  logic [NUM_TX-1:0] tx_mask, tx_masked;
  logic [NUM_RX-1:0] rx_mask, rx_masked;
  logic [DMA_W-1:0]  dm_mask, dm_masked, dm_src;
  logic [7:0]        a;
  logic              eoi_wr;
  logic [DATA_W-1:0] rd_next;

  assign a      = 8'(reg_addr);
  assign dm_src = {host_err, 1'b0};
  assign eoi_wr = reg_wr && (a == A_EOI);

  irq_mask_group #(.W(NUM_TX)) u_tx (
    .clk(clk), .rst_n(rst_n), .src(tx_src),
    .set_we(reg_wr && a == A_TX_SET), .clr_we(reg_wr && a == A_TX_CLR),
    .wbits(reg_wdata[NUM_TX-1:0]), .mask_q(tx_mask), .masked(tx_masked));

  irq_mask_group #(.W(NUM_RX)) u_rx (
    .clk(clk), .rst_n(rst_n), .src(rx_src),
    .set_we(reg_wr && a == A_RX_SET), .clr_we(reg_wr && a == A_RX_CLR),
    .wbits(reg_wdata[NUM_RX-1:0]), .mask_q(rx_mask), .masked(rx_masked));

  irq_mask_group #(.W(DMA_W), .IMPL(DMA_IMPL)) u_dma (
    .clk(clk), .rst_n(rst_n), .src(dm_src),
    .set_we(reg_wr && a == A_DM_SET), .clr_we(reg_wr && a == A_DM_CLR),
    .wbits(reg_wdata[DMA_W-1:0]), .mask_q(dm_mask), .masked(dm_masked));

  irq_arm u_arm (
    .clk(clk), .rst_n(rst_n),
    .pending(|{tx_masked, rx_masked, dm_masked}),
    .eoi_wr(eoi_wr), .irq_pulse(irq_pulse));

  always_comb begin
    rd_next = '0;
    unique case (a)
      A_TX_RAW:           rd_next = DATA_W'(tx_src);
      A_TX_MSK:           rd_next = DATA_W'(tx_masked);
      A_TX_SET, A_TX_CLR: rd_next = DATA_W'(tx_mask);
      A_RX_RAW:           rd_next = DATA_W'(rx_src);
      A_RX_MSK:           rd_next = DATA_W'(rx_masked);
      A_RX_SET, A_RX_CLR: rd_next = DATA_W'(rx_mask);
      A_DM_RAW:           rd_next = DATA_W'(dm_src);
      A_DM_MSK:           rd_next = DATA_W'(dm_masked);
      A_DM_SET, A_DM_CLR: rd_next = DATA_W'(dm_mask);
      A_VECTOR:           rd_next = {{VEC_PAD{1'b0}}, rx_masked, tx_masked};
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_pulse && reg_rdata == '0));
  // R6
  dma_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dm_mask[0]);
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_src = '0, rx_src = '0;
  logic        host_err = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tx_src(tx_src), .rx_src(rx_src),
    .host_err(host_err), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse));

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ad, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = ad;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_pulse !== e) begin
      errors++;
      $display("FAIL %s: irq_pulse=%b expected=%b", t, irq_pulse, e);
    end
  endtask

  // expects 0 now, a pulse on the next cycle, then 0
  task automatic expect_pulse(input string t);
    chk_irq(1'b0, t);
    @(negedge clk); chk_irq(1'b1, t);
    @(negedge clk); chk_irq(1'b0, t);
  endtask

  task automatic expect_none(input string t);
    for (int i = 0; i < 3; i++) begin
      chk_irq(1'b0, t);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R1 reset irq");
    checks++;
    if (reg_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 reset rdata: %h expected 0", reg_rdata);
    end
    rd(8'h88, 32'h0, "R1 tx mask reset");
    rd(8'hB8, 32'h0, "R1 dma mask reset");

    tx_src = 8'hA5;
    rd(8'h80, 32'hA5, "R5 tx raw");
    rd(8'h84, 32'h00, "R5 tx masked with zero mask");
    expect_none("R7 no pulse with zero mask");

    wr(8'h88, 32'h05);
    expect_pulse("R7 first pulse");
    rd(8'h88, 32'h05, "R4 set alias");
    rd(8'h8C, 32'h05, "R4 clear alias");
    rd(8'h84, 32'h05, "R5 tx masked");
    rd(8'h90, 32'h0005, "R9 vector tx");
    expect_none("R7 no repeat before eoi");

    wr(8'h88, 32'h00);
    rd(8'h88, 32'h05, "R2 zero bits no effect");
    wr(8'h8C, 32'h01);
    rd(8'h88, 32'h04, "R3 clear one bit");

    wr(8'h94, 32'h0);
    expect_pulse("R8 eoi re-pulse while pending");

    rx_src = 8'h3C;
    wr(8'hA8, 32'hF0);
    expect_none("R7 disarmed no pulse");
    rd(8'hA4, 32'h30, "R5 rx masked");
    rd(8'h90, 32'h3004, "R9 vector rx and tx");

    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hAC, 32'hFFFF_FFFF);
    rd(8'h88, 32'h0, "R3 tx all ones clear");
    rd(8'hA8, 32'h0, "R3 rx all ones clear");

    wr(8'h94, 32'h0);
    expect_none("R8 eoi without pending");

    host_err = 1'b1;
    rd(8'hB0, 32'h2, "R6 host error on bit 1");
    wr(8'hB8, 32'hFFFF_FFFF);
    expect_pulse("R8 armed pulse on new source");
    rd(8'hBC, 32'h2, "R6 dma only bit 1 implemented");
    rd(8'hB4, 32'h2, "R5 dma masked");

    tx_src = 8'h80;
    rd(8'h80, 32'h80, "R6 tx channel 7 bit");
    wr(8'h80, 32'hFF);
    wr(8'h84, 32'hFF);
    wr(8'h90, 32'hFFFF);
    wr(8'hFC, 32'hFF);
    rd(8'h88, 32'h0, "R10 tx mask untouched");
    rd(8'hA8, 32'h0, "R10 rx mask untouched");
    rd(8'h80, 32'h80, "R10 raw status untouched");
    rd(8'hFC, 32'h0, "R10 unmapped reads zero");
    rd(8'h94, 32'h0, "R10 eoi reads zero");
    expect_none("R10 no rearm from ignored writes");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule